// File: doc/BRIEF.md
# Converter Serial Port with Data-Ready Handshake

This block is the digital serial front end of a data converter. An external controller talks to it as an SPI slave over chip select, serial clock, data in and data out. The converter core hands it each finished result through a one-cycle strobe. The block stores that result in a 24-bit output register and pulls an active-low ready flag. A read command shifts the result out and releases the flag. A second strobe from the core announces that the register is about to change, and it raises the flag so that nobody reads a result that is being replaced.

All serial inputs are brought into the system clock domain through two-flop synchronisers, and serial clock edges are detected there. The system clock must run at least four times faster than the serial clock. Commands are 8-bit opcodes, sent MSB first. A small control register holds seven writable bits, and its top bit shows the ready flag. A reset opcode returns every register to its power-on value.

Chip select can be tied low so that only three wires are used. In that case framing is recovered by a timeout. When three falling edges of the ready flag occur with no serial clock edge between them, the next serial clock edge starts a new command.

Top module: `cnv_spi_port`

## Requirements
- R1: While chip select (active low) is high, the bit counter and command state are held cleared and the data-out enable is low. A command cut off by chip select going high changes no register.
- R2: SDI is sampled on the rising serial clock edge. The first 8 bits of a transaction are an opcode, MSB first: 0x01 reads the output register, 0x10 reads the control register, 0x50 writes the control register, 0xFE is the reset command.
- R3: After opcode 0x01, the 24-bit output register is shifted out MSB first. Each bit changes on a falling serial clock edge, and the first bit is driven after the falling edge that follows the eighth rising edge.
- R4: The data-out enable is low during opcode bits, during write bits and when idle. It is high only from the first data falling edge until the falling edge after the last data bit.
- R5: A new-sample strobe loads the output register, and the ready flag is low from the next clock cycle.
- R6: The ready flag goes high once all 24 bits of a data read have been clocked in by rising edges. A read cut short leaves the flag unchanged.
- R7: A pre-update strobe drives the ready flag high in the next cycle. When a new-sample strobe arrives in the same cycle, the new-sample strobe wins and the flag goes low.
- R8: Opcode 0x10 returns 8 bits, MSB first. Bit 7 is the current ready-flag pin level (1 = not ready) and bits 6:0 are the writable control bits. Opcode 0x50 writes bits 6:0 from the following byte and ignores its bit 7.
- R9: With chip select low, three falling edges of the ready flag with no serial clock edge between them make the next serial clock edge clear the framing. A rising edge in that case is taken as bit 7 of a new opcode.
- R10: With fewer than three such ready falls, a paused transaction resumes its bit count where it stopped.
- R11: The reset command (0xFE) clears the output register and the control bits and raises the ready flag.
- R12: After system reset, the ready flag is high, the output register is zero, the control bits are zero and the data-out enable is low.
- R13: An opcode other than the four above does nothing, and the next 8 bits are decoded as a new opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| csN | input | 1 | Chip select, active low (may be tied low) |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| sdoData | output | 1 | Serial data out value to the pad |
| sdoEn | output | 1 | Pad output enable; pad is high impedance when low |
| sampleValid | input | 1 | One-cycle strobe: new result on sampleData |
| sampleData | input | 24 | New conversion result |
| preUpdate | input | 1 | One-cycle strobe: output register about to change |
| drdyN | output | 1 | Ready flag, low when an unread result is held |

## Verification
The hardest case to reach is the three-wire timeout. It needs a command stopped partway through, with chip select held low. While the serial clock is paused, the core strobes must produce an exact number of ready-flag falling edges. The bench pauses after three opcode bits and alternates pre-update and new-sample strobes to make exactly three falls, then checks that a full read opcode is decoded from scratch. It then repeats the pause with only two falls and checks that the old bit count carries on: no output is driven, the flag stays low, and a later control read shows that alignment came back.

// File: rtl/cnv_spi_pkg.sv
package cnv_spi_pkg;

  localparam logic [7:0] OP_RD_DATA = 8'h01;
  localparam logic [7:0] OP_RD_CTRL = 8'h10;
  localparam logic [7:0] OP_WR_CTRL = 8'h50;
  localparam logic [7:0] OP_RESET   = 8'hFE;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_TX  = 2'd1,
    PH_WR  = 2'd2
  } phase_e;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic frameClr;   // framing cleared: drop the output enable
    logic shiftIn;    // capture synchronised SDI into receive shifter
    logic loadDor;    // copy output register into transmit shifter
    logic loadCtrl;   // copy control register into transmit shifter
    logic txShift;    // falling edge in transmit phase: present next bit
    logic txStop;     // falling edge outside transmit phase
    logic writeCtrl;  // update writable control bits from receive byte
    logic readDone;   // last bit of a data read clocked in
    logic doReset;    // reset opcode decoded
  } ctrl_stb_t;

endpackage

// File: rtl/cnv_spi_sync.sv
module cnv_spi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= RST_VAL;
      else       stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/cnv_spi_ctrl.sv
module cnv_spi_ctrl
  import cnv_spi_pkg::*;
#(
  parameter int DW = 24,
  parameter int CW = 8,
  parameter int TMO_PERIODS = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csHigh,
  input  logic          sclkSync,
  input  logic          drdyN,
  input  logic [CW-1:0] rxNext,
  output ctrl_stb_t     stb
);

  localparam int LENW = $clog2(DW + 1);
  localparam int TW   = $clog2(TMO_PERIODS + 1);

  logic            sclkPrev;
  logic            drdyPrev;
  logic [TW-1:0]   tmoCnt;
  phase_e          phase;
  logic [LENW-1:0] bitCnt;
  logic [LENW-1:0] txLen;
  logic            txIsDor;

  logic            rise, fall, drdyFall, tmoHit, restart;
  phase_e          effPhase;
  logic [LENW-1:0] effCnt;
  logic            opDone, txDone;

  assign rise     = sclkSync & ~sclkPrev;
  assign fall     = ~sclkSync & sclkPrev;
  assign drdyFall = drdyPrev & ~drdyN;
  assign tmoHit   = (tmoCnt == TW'(TMO_PERIODS));
  assign restart  = tmoHit & (rise | fall);

  always_comb begin
    effPhase = restart ? PH_CMD : phase;
    effCnt   = restart ? '0 : bitCnt;
    opDone   = (effCnt == LENW'(CW - 1));
    txDone   = (effCnt == txLen - LENW'(1));
  end

  always_comb begin
    stb = '0;
    if (csHigh) begin
      stb.frameClr = 1'b1;
    end else begin
      stb.frameClr = restart;
      if (rise) begin
        case (effPhase)
          PH_CMD: begin
            stb.shiftIn = 1'b1;
            if (opDone) begin
              case (rxNext)
                OP_RD_DATA: stb.loadDor  = 1'b1;
                OP_RD_CTRL: stb.loadCtrl = 1'b1;
                OP_RESET:   stb.doReset  = 1'b1;
                default:    ;
              endcase
            end
          end
          PH_WR: begin
            stb.shiftIn   = 1'b1;
            stb.writeCtrl = opDone;
          end
          PH_TX:   stb.readDone = txDone & txIsDor;
          default: ;
        endcase
      end
      if (fall) begin
        if (effPhase == PH_TX) stb.txShift = 1'b1;
        else                   stb.txStop  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      drdyPrev <= 1'b1;
      tmoCnt   <= '0;
      phase    <= PH_CMD;
      bitCnt   <= '0;
      txLen    <= LENW'(CW);
      txIsDor  <= 1'b0;
    end else begin
      sclkPrev <= sclkSync;
      drdyPrev <= drdyN;

      if (csHigh || rise || fall)  tmoCnt <= '0;
      else if (drdyFall && !tmoHit) tmoCnt <= tmoCnt + 1'b1;

      if (csHigh) begin
        phase  <= PH_CMD;
        bitCnt <= '0;
      end else if (rise) begin
        case (effPhase)
          PH_CMD: begin
            if (opDone) begin
              bitCnt <= '0;
              case (rxNext)
                OP_RD_DATA: begin
                  phase   <= PH_TX;
                  txLen   <= LENW'(DW);
                  txIsDor <= 1'b1;
                end
                OP_RD_CTRL: begin
                  phase   <= PH_TX;
                  txLen   <= LENW'(CW);
                  txIsDor <= 1'b0;
                end
                OP_WR_CTRL: phase <= PH_WR;
                default:    phase <= PH_CMD;
              endcase
            end else begin
              phase  <= PH_CMD;
              bitCnt <= effCnt + 1'b1;
            end
          end
          PH_WR: begin
            if (opDone) begin
              phase  <= PH_CMD;
              bitCnt <= '0;
            end else begin
              bitCnt <= effCnt + 1'b1;
            end
          end
          PH_TX: begin
            if (txDone) begin
              phase  <= PH_CMD;
              bitCnt <= '0;
            end else begin
              bitCnt <= effCnt + 1'b1;
            end
          end
          default: begin
            phase  <= PH_CMD;
            bitCnt <= '0;
          end
        endcase
      end else if (fall && restart) begin
        phase  <= PH_CMD;
        bitCnt <= '0;
      end
    end
  end

endmodule

// File: rtl/cnv_spi_dp.sv
module cnv_spi_dp
  import cnv_spi_pkg::*;
#(
  parameter int DW = 24,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_stb_t     stb,
  input  logic          sdiSync,
  input  logic          sampleValid,
  input  logic [DW-1:0] sampleData,
  input  logic          preUpdate,
  output logic [CW-1:0] rxNext,
  output logic [CW-1:0] ctrlReg,
  output logic          drdyN,
  output logic          sdoData,
  output logic          sdoEn
);

  logic [DW-1:0] dorQ;
  logic [DW-1:0] txQ;
  logic [CW-1:0] rxQ;
  logic [CW-2:0] ctrlLow;
  logic          drdyQ;
  logic          sdoQ;
  logic          oeQ;

  assign rxNext  = {rxQ[CW-2:0], sdiSync};
  assign ctrlReg = {drdyQ, ctrlLow};
  assign drdyN   = drdyQ;
  assign sdoData = sdoQ;
  assign sdoEn   = oeQ;

  // receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxQ <= '0;
    else if (stb.shiftIn) rxQ <= rxNext;
  end

  // output register and ready flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dorQ  <= '0;
      drdyQ <= 1'b1;
    end else if (stb.doReset) begin
      dorQ  <= '0;
      drdyQ <= 1'b1;
    end else if (sampleValid) begin
      dorQ  <= sampleData;
      drdyQ <= 1'b0;
    end else if (preUpdate || stb.readDone) begin
      drdyQ <= 1'b1;
    end
  end

  // writable control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ctrlLow <= '0;
    else if (stb.doReset)   ctrlLow <= '0;
    else if (stb.writeCtrl) ctrlLow <= rxNext[CW-2:0];
  end

  // transmit shifter and pad drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txQ  <= '0;
      sdoQ <= 1'b0;
      oeQ  <= 1'b0;
    end else begin
      if (stb.loadDor)       txQ <= dorQ;
      else if (stb.loadCtrl) txQ <= {ctrlReg, {(DW-CW){1'b0}}};
      else if (stb.txShift)  txQ <= {txQ[DW-2:0], 1'b0};

      if (stb.frameClr) begin
        oeQ <= 1'b0;
      end else if (stb.txShift) begin
        oeQ  <= 1'b1;
        sdoQ <= txQ[DW-1];
      end else if (stb.txStop) begin
        oeQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cnv_spi_port.sv
module cnv_spi_port
  import cnv_spi_pkg::*;
#(
  parameter int DW = 24,
  parameter int CW = 8,
  parameter int TMO_PERIODS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdoData,
  output logic          sdoEn,
  input  logic          sampleValid,
  input  logic [DW-1:0] sampleData,
  input  logic          preUpdate,
  output logic          drdyN
);

  logic [2:0]    syncOut;
  logic          csHigh, sclkSync, sdiSync;
  ctrl_stb_t     stb;
  logic [CW-1:0] rxNext;
  logic [CW-1:0] ctrlReg;

  cnv_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    ({csN, sclk, sdi}),
    .q    (syncOut)
  );

  assign {csHigh, sclkSync, sdiSync} = syncOut;

  cnv_spi_ctrl #(.DW(DW), .CW(CW), .TMO_PERIODS(TMO_PERIODS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csHigh   (csHigh),
    .sclkSync (sclkSync),
    .drdyN    (drdyN),
    .rxNext   (rxNext),
    .stb      (stb)
  );

  cnv_spi_dp #(.DW(DW), .CW(CW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .sdiSync     (sdiSync),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .preUpdate   (preUpdate),
    .rxNext      (rxNext),
    .ctrlReg     (ctrlReg),
    .drdyN       (drdyN),
    .sdoData     (sdoData),
    .sdoEn       (sdoEn)
  );

endmodule

// File: rtl/cnv_spi_chk.sv
module cnv_spi_chk
  import cnv_spi_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          sampleValid,
  input logic          preUpdate,
  input logic          drdyN,
  input logic          sdoEn,
  input logic          csHigh,
  input ctrl_stb_t     stb,
  input logic [CW-1:0] ctrlReg
);

  // R5
  drdy_low_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !stb.doReset |=> !drdyN);

  // R7
  drdy_high_pre_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    preUpdate && !sampleValid |=> drdyN);

  // R6
  drdy_high_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.readDone && !sampleValid |=> drdyN);

  // R1
  sdo_off_cs_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> !sdoEn);

  // R2
  single_command_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadDor, stb.loadCtrl, stb.writeCtrl, stb.doReset}));

  // R11
  reset_cmd_defaults_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.doReset |=> drdyN && (ctrlReg[CW-2:0] == '0));

endmodule

bind cnv_spi_port cnv_spi_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .preUpdate   (preUpdate),
  .drdyN       (drdyN),
  .sdoEn       (sdoEn),
  .csHigh      (csHigh),
  .stb         (stb),
  .ctrlReg     (ctrlReg)
);

// File: tb/tb_cnv_spi_port.sv
module tb_cnv_spi_port;

  localparam int DW = 24;
  localparam int H  = 6;   // system clocks per serial clock half period

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic          sampleValid = 1'b0, preUpdate = 1'b0;
  logic [DW-1:0] sampleData = '0;
  logic          sdoData, sdoEn, drdyN;

  cnv_spi_port dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdoData(sdoData), .sdoEn(sdoEn), .sampleValid(sampleValid),
    .sampleData(sampleData), .preUpdate(preUpdate), .drdyN(drdyN)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  // behavioural model
  bit            modelDrdy = 1'b1;
  logic [DW-1:0] sampleQ[$];
  logic [6:0]    modelCtrl = '0;
  bit            monOn = 1'b0;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // ready flag compared against the model on every clock while tracking
  always @(posedge clk) begin
    #1;
    if (monOn && rstN) check("R5", {31'd0, drdyN}, {31'd0, modelDrdy}, "ready flag vs model");
  end

  task automatic newSample(input logic [DW-1:0] d);
    @(negedge clk);
    sampleValid = 1'b1; sampleData = d;
    modelDrdy = 1'b0; sampleQ.push_back(d);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic preUpd();
    @(negedge clk);
    preUpdate = 1'b1; modelDrdy = 1'b1;
    @(negedge clk);
    preUpdate = 1'b0;
  endtask

  task automatic spiBit(input logic b, output logic o, output logic en);
    @(negedge clk);
    sdi = b;
    repeat (H) @(negedge clk);
    o = sdoData; en = sdoEn;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] op, input int nRead, input int nWrite,
                      input logic [7:0] wr, output logic [23:0] rd,
                      output bit quietOk, output bit drivenOk);
    logic o, en;
    rd = '0; quietOk = 1; drivenOk = 1;
    for (int i = 0; i < 8; i++) begin
      spiBit(op[7-i], o, en);
      if (en) quietOk = 0;
    end
    for (int i = 0; i < nRead; i++) begin
      spiBit(1'b0, o, en);
      rd = {rd[22:0], o};
      if (!en) drivenOk = 0;
    end
    for (int i = 0; i < nWrite; i++) begin
      spiBit(wr[7-i], o, en);
      if (en) quietOk = 0;
    end
    repeat (H) @(negedge clk);
    if (sdoEn) quietOk = 0;
  endtask

  task automatic readData(input logic [23:0] exp, input string req);
    logic [23:0] rd; bit q, d;
    monOn = 0;
    xfer(8'h01, 24, 0, 8'h00, rd, q, d);
    modelDrdy = 1'b1;
    monOn = 1;
    check(req, rd, exp, "data read value");
    check("R4", {31'd0, q}, 32'd1, "output idle outside data bits");
    check("R4", {31'd0, d}, 32'd1, "output driven during data bits");
    check("R6", {31'd0, drdyN}, 32'd1, "ready high after full read");
  endtask

  task automatic readCtrl(input logic [7:0] exp, input string req);
    logic [23:0] rd; bit q, d;
    xfer(8'h10, 8, 0, 8'h00, rd, q, d);
    check(req, rd, {16'd0, exp}, "control read value");
    check("R4", {31'd0, q & d}, 32'd1, "control read drive window");
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    logic [23:0] rd; bit q, d;
    xfer(8'h50, 0, 8, v, rd, q, d);
    modelCtrl = v[6:0];
    check("R4", {31'd0, q}, 32'd1, "output idle during write");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic o, en;
    logic [23:0] rd;
    bit q, d, sawEn;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12", {31'd0, drdyN}, 32'd1, "ready after reset");
    check("R12", {31'd0, sdoEn}, 32'd0, "output enable after reset");
    monOn = 1;
    csN = 1'b0;
    repeat (4) @(negedge clk);
    readCtrl(8'h80, "R12");
    readData(24'h0, "R12");

    // R5 load and R3 read
    newSample(24'hA5C3F1);
    repeat (3) @(negedge clk);
    check("R5", {31'd0, drdyN}, 32'd0, "ready low after sample");
    readCtrl({1'b0, modelCtrl}, "R8");
    readData(sampleQ[$], "R3");

    // R7 pre-update and priority
    newSample(24'h2468AC);
    preUpd();
    repeat (2) @(negedge clk);
    check("R7", {31'd0, drdyN}, 32'd1, "pre-update raises ready");
    @(negedge clk);
    sampleValid = 1'b1; preUpdate = 1'b1; sampleData = 24'h13579B;
    modelDrdy = 1'b0; sampleQ.push_back(24'h13579B);
    @(negedge clk);
    sampleValid = 1'b0; preUpdate = 1'b0;
    check("R7", {31'd0, drdyN}, 32'd0, "new sample wins over pre-update");
    readData(24'h13579B, "R3");

    // R8 control register
    writeCtrl(8'h5A);
    readCtrl({1'b1, 7'h5A}, "R8");
    writeCtrl(8'hFF);
    newSample(24'h00F00F);
    readCtrl({1'b0, 7'h7F}, "R8");

    // R13 unknown opcode
    xfer(8'h33, 0, 0, 8'h00, rd, q, d);
    check("R13", {31'd0, q}, 32'd1, "unknown opcode drives nothing");
    readCtrl({1'b0, 7'h7F}, "R13");

    // R1 abort a write by chip select
    for (int i = 0; i < 5; i++) spiBit(i[0], o, en);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    readCtrl({1'b0, 7'h7F}, "R1");
    // R1 abort a data read partway
    monOn = 0;
    for (int i = 0; i < 8; i++) spiBit(i == 7, o, en);
    for (int i = 0; i < 5; i++) spiBit(1'b0, o, en);
    check("R1", {31'd0, sdoEn}, 32'd1, "driving before abort");
    csN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {31'd0, sdoEn}, 32'd0, "output off with chip select high");
    check("R6", {31'd0, drdyN}, 32'd0, "partial read keeps ready low");
    monOn = 1;
    csN = 1'b0;
    repeat (4) @(negedge clk);

    // R9 timeout with three ready falls
    for (int i = 0; i < 3; i++) spiBit(1'b1, o, en);
    for (int i = 0; i < 3; i++) begin
      preUpd();
      newSample(24'hC0FFEE + i);
    end
    readData(24'hC0FFEE + 2, "R9");

    // R10 only two falls: old framing continues
    for (int i = 0; i < 3; i++) spiBit(1'b0, o, en);
    for (int i = 0; i < 2; i++) begin
      preUpd();
      newSample(24'h0BADF0 + i);
    end
    sawEn = 0;
    for (int i = 0; i < 8; i++) begin
      spiBit(i == 7, o, en);
      if (en) sawEn = 1;
    end
    for (int i = 0; i < 5; i++) begin
      spiBit(1'b0, o, en);
      if (en) sawEn = 1;
    end
    repeat (H) @(negedge clk);
    check("R10", {31'd0, sawEn}, 32'd0, "no read decoded across short pause");
    check("R10", {31'd0, drdyN}, 32'd0, "ready still low");
    readCtrl({1'b0, 7'h7F}, "R10");

    // R11 reset command
    writeCtrl(8'h11);
    newSample(24'h777777);
    monOn = 0;
    xfer(8'hFE, 0, 0, 8'h00, rd, q, d);
    modelDrdy = 1'b1; modelCtrl = '0;
    monOn = 1;
    check("R11", {31'd0, drdyN}, 32'd1, "ready high after reset command");
    readCtrl(8'h80, "R11");
    readData(24'h0, "R11");

    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule